// File: doc/BRIEF.md
# Bridge Configuration Access Router

This block sits beside the configuration decoder of a PCI-to-PCI bridge. Each cycle in which a strobe is raised, it looks at one configuration address. It also takes the direction flag of that address (arrived from the upstream or the downstream side), the write flag, the local device-select flag and the three bus-number registers. From these it settles what the bridge must do with the access. Possible outcomes are: drop it, answer it from the bridge's own register space, pass it through to the other side unchanged, turn it into a local-segment (Type 0) access on the downstream side, or run a special cycle on one of the two sides.

The outcome is registered, so the action code and the outgoing address are valid one clock after the strobe. When an access is converted to Type 0, the outgoing address carries a one-hot device select in its upper half, together with the device, function and register fields. Bus-level signalling, data movement and the register file itself are handled elsewhere.

Top module: `p2p_cfg_router`

## Requirements
- R1: `rsp_valid_o` is high exactly in the cycle after `req_valid_i` was high. The action and address outputs change only on a strobe and otherwise hold their last values.
- R2: An address with bit 0 = 0 is a Type 0 access. It gives action CLAIM (1) with the address unchanged only when it arrives on the upstream side with `req_self_sel_i` high. In every other case it gives IGNORE (0).
- R3: A Type 1 access (bit 0 = 1) arriving upstream, whose bus field [23:16] is greater than the secondary number and not greater than the subordinate number, gives FWD_T1 (2) with the address unchanged.
- R4: A Type 1 access arriving upstream, whose bus field equals the secondary number and which is not a special-cycle request, gives CONV_T0 (3). The output address has bits [1:0] = 00, bits [10:2] copied, the device field [15:11] copied, and bit 16+device set when the device is below 16. All other upper bits are zero.
- R5: A special-cycle request is a Type 1 write with device 1Fh, function 7 and register 0. Arriving upstream with bus equal to the secondary number, it gives SPC_SEC (4) with the address unchanged.
- R6: A special-cycle request arriving downstream gives SPC_PRI (5) with the address unchanged when its bus equals the primary number and lies outside the range secondary..subordinate.
- R7: A special-cycle request arriving downstream, whose bus is outside secondary..subordinate and differs from the primary number, gives FWD_T1 (2) upstream with the address unchanged.
- R8: Every other access gives IGNORE (0) with a zero output address. This covers upstream Type 1 accesses outside the range, all downstream accesses that are not special-cycle requests, and downstream special-cycle requests whose bus is inside secondary..subordinate. Address bit 1 never affects the outcome.
- R9: While `rst_ni` is low, `rsp_valid_o` is 0, the action is IGNORE and the address is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access strobe |
| req_addr_i | input | 32 | Configuration address |
| req_write_i | input | 1 | Access is a write |
| req_from_sec_i | input | 1 | 1 = arrived on the downstream side, 0 = upstream |
| req_self_sel_i | input | 1 | Local device select for Type 0 accesses |
| pri_bus_i | input | 8 | Primary bus number |
| sec_bus_i | input | 8 | Secondary bus number |
| sub_bus_i | input | 8 | Subordinate bus number |
| rsp_valid_o | output | 1 | Decision valid |
| rsp_action_o | output | 3 | Action code (see R2 to R8) |
| rsp_addr_o | output | 32 | Outgoing address |

## Verification
The sweep puts every bus value one below, at and beyond the secondary and subordinate numbers. A design whose range compare is off by one would then forward an access meant for conversion, or drop one for the last subordinate bus. Special-cycle patterns are sent as reads and with one field off. A decoder that left out the write flag or a field would then turn a plain conversion into a special cycle. Devices 15 and 16 are both used, which exposes a select bit placed one position off or a select that wraps. Downstream accesses are sent with the primary number inside the downstream range, so a design that tests the primary match before the range check would wrongly start an upstream special cycle.

// File: rtl/p2p_cfgr_pkg.sv
package p2p_cfgr_pkg;

  typedef enum logic [2:0] {
    ACT_IGNORE  = 3'd0,
    ACT_CLAIM   = 3'd1,
    ACT_FWD_T1  = 3'd2,
    ACT_CONV_T0 = 3'd3,
    ACT_SPC_SEC = 3'd4,
    ACT_SPC_PRI = 3'd5
  } cfgr_act_e;

  typedef struct packed {
    logic is_t1;
    logic spc_req;
    logic bus_eq_sec;
    logic bus_eq_pri;
    logic bus_below;   // sec < bus <= sub
    logic bus_in_rng;  // sec <= bus <= sub
  } cfgr_flags_t;

endpackage

// File: rtl/p2p_cfgr_decode.sv
module p2p_cfgr_decode
  import p2p_cfgr_pkg::*;
#(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned DEV_W = 5,
  parameter int unsigned FN_W  = 3,
  parameter int unsigned REG_W = 6
) (
  input  logic             fmt_i,
  input  logic             write_i,
  input  logic [BUS_W-1:0] bus_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic [FN_W-1:0]  fn_i,
  input  logic [REG_W-1:0] reg_i,
  input  logic [BUS_W-1:0] pri_bus_i,
  input  logic [BUS_W-1:0] sec_bus_i,
  input  logic [BUS_W-1:0] sub_bus_i,
  output cfgr_flags_t      flags_o
);

  logic ge_sec, gt_sec, le_sub;

  assign ge_sec = (bus_i >= sec_bus_i);
  assign gt_sec = (bus_i >  sec_bus_i);
  assign le_sub = (bus_i <= sub_bus_i);

  always_comb begin
    flags_o            = '0;
    flags_o.is_t1      = fmt_i;
    flags_o.spc_req    = fmt_i && write_i && (&dev_i) && (&fn_i) && (reg_i == '0);
    flags_o.bus_eq_sec = (bus_i == sec_bus_i);
    flags_o.bus_eq_pri = (bus_i == pri_bus_i);
    flags_o.bus_below  = gt_sec && le_sub;
    flags_o.bus_in_rng = ge_sec && le_sub;
  end

endmodule

// File: rtl/p2p_cfgr_action.sv
module p2p_cfgr_action
  import p2p_cfgr_pkg::*;
(
  input  cfgr_flags_t flags_i,
  input  logic        from_sec_i,
  input  logic        self_sel_i,
  output cfgr_act_e   act_o
);

  always_comb begin
    act_o = ACT_IGNORE;
    if (!flags_i.is_t1) begin
      // local-segment access: only the upstream side may reach the bridge
      if (!from_sec_i && self_sel_i) act_o = ACT_CLAIM;
    end else if (!from_sec_i) begin
      if (flags_i.bus_eq_sec)     act_o = flags_i.spc_req ? ACT_SPC_SEC : ACT_CONV_T0;
      else if (flags_i.bus_below) act_o = ACT_FWD_T1;
    end else if (flags_i.spc_req) begin
      // downstream range wins over the primary match
      if (flags_i.bus_in_rng)      act_o = ACT_IGNORE;
      else if (flags_i.bus_eq_pri) act_o = ACT_SPC_PRI;
      else                         act_o = ACT_FWD_T1;
    end
  end

endmodule

// File: rtl/p2p_cfgr_t0_rewrite.sv
module p2p_cfgr_t0_rewrite #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DEV_W   = 5,
  parameter int unsigned FN_W    = 3,
  parameter int unsigned REG_W   = 6,
  parameter int unsigned SEL_LSB = 16
) (
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [FN_W-1:0]   fn_i,
  input  logic [REG_W-1:0]  reg_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int unsigned REG_LSB = 2;
  localparam int unsigned FN_LSB  = REG_LSB + REG_W;
  localparam int unsigned DEV_LSB = FN_LSB + FN_W;
  localparam int unsigned SEL_W   = ADDR_W - SEL_LSB;

  logic [SEL_W-1:0] sel;

  for (genvar i = 0; i < SEL_W; i++) begin : g_sel
    assign sel[i] = (int'(dev_i) == i);
  end

  always_comb begin
    addr_o                       = '0;
    addr_o[REG_LSB +: REG_W]     = reg_i;
    addr_o[FN_LSB  +: FN_W]      = fn_i;
    addr_o[DEV_LSB +: DEV_W]     = dev_i;
    addr_o[SEL_LSB +: SEL_W]     = sel;
  end

endmodule

// File: rtl/p2p_cfg_router.sv
module p2p_cfg_router
  import p2p_cfgr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned DEV_W   = 5,
  parameter int unsigned FN_W    = 3,
  parameter int unsigned REG_W   = 6,
  parameter int unsigned SEL_LSB = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              req_from_sec_i,
  input  logic              req_self_sel_i,
  input  logic [BUS_W-1:0]  pri_bus_i,
  input  logic [BUS_W-1:0]  sec_bus_i,
  input  logic [BUS_W-1:0]  sub_bus_i,
  output logic              rsp_valid_o,
  output logic [2:0]        rsp_action_o,
  output logic [ADDR_W-1:0] rsp_addr_o
);

  localparam int unsigned REG_LSB = 2;
  localparam int unsigned FN_LSB  = REG_LSB + REG_W;
  localparam int unsigned DEV_LSB = FN_LSB + FN_W;
  localparam int unsigned BUS_LSB = DEV_LSB + DEV_W;

  cfgr_flags_t       flags;
  cfgr_act_e         act_d;
  logic [ADDR_W-1:0] t0_addr;
  logic [ADDR_W-1:0] addr_d;

  p2p_cfgr_decode #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .REG_W(REG_W)
  ) u_decode (
    .fmt_i     (req_addr_i[0]),
    .write_i   (req_write_i),
    .bus_i     (req_addr_i[BUS_LSB +: BUS_W]),
    .dev_i     (req_addr_i[DEV_LSB +: DEV_W]),
    .fn_i      (req_addr_i[FN_LSB  +: FN_W]),
    .reg_i     (req_addr_i[REG_LSB +: REG_W]),
    .pri_bus_i (pri_bus_i),
    .sec_bus_i (sec_bus_i),
    .sub_bus_i (sub_bus_i),
    .flags_o   (flags)
  );

  p2p_cfgr_action u_action (
    .flags_i    (flags),
    .from_sec_i (req_from_sec_i),
    .self_sel_i (req_self_sel_i),
    .act_o      (act_d)
  );

  p2p_cfgr_t0_rewrite #(
    .ADDR_W(ADDR_W), .DEV_W(DEV_W), .FN_W(FN_W), .REG_W(REG_W), .SEL_LSB(SEL_LSB)
  ) u_t0 (
    .dev_i  (req_addr_i[DEV_LSB +: DEV_W]),
    .fn_i   (req_addr_i[FN_LSB  +: FN_W]),
    .reg_i  (req_addr_i[REG_LSB +: REG_W]),
    .addr_o (t0_addr)
  );

  always_comb begin
    unique case (act_d)
      ACT_IGNORE:  addr_d = '0;
      ACT_CONV_T0: addr_d = t0_addr;
      default:     addr_d = req_addr_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_action_o <= ACT_IGNORE;
      rsp_addr_o   <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_action_o <= act_d;
        rsp_addr_o   <= addr_d;
      end
    end
  end

endmodule

// File: rtl/p2p_cfg_router_chk.sv
module p2p_cfg_router_chk
  import p2p_cfgr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SEL_LSB = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_write_i,
  input logic              req_from_sec_i,
  input logic              rsp_valid_o,
  input logic [2:0]        rsp_action_o,
  input logic [ADDR_W-1:0] rsp_addr_o
);

  assert_resp_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_no_spurious_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  assert_type0_stays_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_addr_i[0]) |=>
      (rsp_action_o == ACT_IGNORE || rsp_action_o == ACT_CLAIM));

  assert_pass_unchanged_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_action_o == ACT_FWD_T1) |-> (rsp_addr_o == $past(req_addr_i)));

  assert_t0_shape_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_action_o == ACT_CONV_T0) |->
      (rsp_addr_o[1:0] == 2'b00 && $onehot0(rsp_addr_o[ADDR_W-1:SEL_LSB])));

  assert_sec_no_down_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_from_sec_i) |=>
      !(rsp_action_o == ACT_CLAIM || rsp_action_o == ACT_CONV_T0 ||
        rsp_action_o == ACT_SPC_SEC));

  assert_sec_read_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_from_sec_i && !req_write_i) |=> (rsp_action_o == ACT_IGNORE));

endmodule

bind p2p_cfg_router p2p_cfg_router_chk #(
  .ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_addr_i     (req_addr_i),
  .req_write_i    (req_write_i),
  .req_from_sec_i (req_from_sec_i),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_action_o   (rsp_action_o),
  .rsp_addr_o     (rsp_addr_o)
);

// File: tb/p2p_cfg_router_tb_top.sv
module p2p_cfg_router_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_from_sec = 1'b0;
  logic        req_self_sel = 1'b0;
  logic [7:0]  pri_bus = '0;
  logic [7:0]  sec_bus = '0;
  logic [7:0]  sub_bus = '0;
  logic        rsp_valid;
  logic [2:0]  rsp_action;
  logic [31:0] rsp_addr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  p2p_cfg_router dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .req_valid_i    (req_valid),
    .req_addr_i     (req_addr),
    .req_write_i    (req_write),
    .req_from_sec_i (req_from_sec),
    .req_self_sel_i (req_self_sel),
    .pri_bus_i      (pri_bus),
    .sec_bus_i      (sec_bus),
    .sub_bus_i      (sub_bus),
    .rsp_valid_o    (rsp_valid),
    .rsp_action_o   (rsp_action),
    .rsp_addr_o     (rsp_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, act, exp);
    end
  endtask

  // expected outcome from the requirement text
  function automatic void model(input logic [31:0] a, input bit wr, input bit from_sec,
                                input bit sel, input logic [7:0] p, input logic [7:0] s,
                                input logic [7:0] u, output logic [2:0] act,
                                output logic [31:0] ea, output string tag);
    logic [7:0] bus;
    logic [4:0] dev;
    bit spc;
    bus = a[23:16];
    dev = a[15:11];
    spc = a[0] && wr && dev == 5'd31 && a[10:8] == 3'd7 && a[7:2] == 6'd0;
    act = 3'd0; ea = '0; tag = "R8";
    if (!a[0]) begin
      tag = "R2";
      if (!from_sec && sel) begin act = 3'd1; ea = a; end
    end else if (!from_sec) begin
      if (bus == s) begin
        if (spc) begin act = 3'd4; ea = a; tag = "R5"; end
        else begin
          act = 3'd3; tag = "R4";
          ea = {16'h0, dev, a[10:2], 2'b00};
          if (dev < 5'd16) ea[16 + int'(dev)] = 1'b1;
        end
      end else if (bus > s && bus <= u) begin
        act = 3'd2; ea = a; tag = "R3";
      end
    end else if (spc && !(bus >= s && bus <= u)) begin
      if (bus == p) begin act = 3'd5; ea = a; tag = "R6"; end
      else          begin act = 3'd2; ea = a; tag = "R7"; end
    end
  endfunction

  task automatic sweep(input logic [7:0] p, input logic [7:0] s, input logic [7:0] u);
    logic [2:0]  e_act;
    logic [31:0] e_addr;
    logic [31:0] a;
    string tag;
    logic [4:0] devs [5] = '{5'd0, 5'd3, 5'd15, 5'd16, 5'd31};
    pri_bus = p; sec_bus = s; sub_bus = u;
    for (int side = 0; side < 2; side++)
    for (int bus = 0; bus < 10; bus++)
    for (int di = 0; di < 5; di++)
    for (int fn = 0; fn < 8; fn += 7)
    for (int rg = 0; rg < 6; rg += 5)
    for (int wr = 0; wr < 2; wr++)
    for (int sl = 0; sl < 2; sl++)
    for (int b1 = 0; b1 < 2; b1++)
    for (int ty = 0; ty < 2; ty++) begin
      a = {8'hC3, 8'(bus), devs[di], 3'(fn), 6'(rg), 1'(b1), 1'(ty)};
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = 1'(wr);
      req_from_sec = 1'(side); req_self_sel = 1'(sl);
      @(negedge clk);
      req_valid = 1'b0;
      model(a, 1'(wr), 1'(side), 1'(sl), p, s, u, e_act, e_addr, tag);
      chk({tag, " action"}, 32'(rsp_action), 32'(e_act));
      chk({tag, " addr"}, rsp_addr, e_addr);
      chk("R1 valid", 32'(rsp_valid), 32'd1);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [2:0]  held_act;
    logic [31:0] held_addr;
    // R9: reset state, with a strobe pending
    req_valid = 1'b1; req_addr = 32'h0000_0001;
    repeat (3) @(negedge clk);
    chk("R9 valid", 32'(rsp_valid), 32'd0);
    chk("R9 action", 32'(rsp_action), 32'd0);
    chk("R9 addr", rsp_addr, 32'd0);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle valid", 32'(rsp_valid), 32'd0);

    sweep(8'd2, 8'd4, 8'd7);
    sweep(8'd0, 8'd1, 8'd1);
    sweep(8'd5, 8'd3, 8'd6);   // primary number inside the downstream range

    // R1: outputs hold while no strobe, even as inputs change
    held_act = rsp_action; held_addr = rsp_addr;
    @(negedge clk);
    req_addr = 32'h0000_0000; req_self_sel = 1'b1; req_from_sec = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 hold valid", 32'(rsp_valid), 32'd0);
    chk("R1 hold action", 32'(rsp_action), 32'(held_act));
    chk("R1 hold addr", rsp_addr, held_addr);

    done = 1'b1;
    finish_run();
  end

endmodule